// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Registers

This block performs 32-bit integer multiplication and division one bit per clock. Both signed and unsigned forms are supported. A command is a two-bit operation code, two 32-bit operands and a one-cycle start pulse. The unit raises busy while it iterates and pulses done when it has finished. Results go into a private pair of result registers, called HI and LO, and not into a general register.

A multiply splits its 64-bit product across the pair: the upper half goes to HI and the lower half to LO. A divide puts the remainder in HI and the quotient in LO. Both registers are always visible on two read ports, so that move-from-HI and move-from-LO operations can copy them out to a general register. Signed commands work on operand magnitudes and correct the signs of the results at the end. A divide by zero finishes in the normal time and leaves a defined result.

Top module: `muldiv_unit`

## Requirements
- R1: While rst_n is low, and until commands are first accepted, busy_o and done_o are 0 and hi_o and lo_o are 0. Commands are accepted from the third rising edge after rst_n goes high.
- R2: Unsigned multiply (op_i = 2'b01): hi_o receives bits 63..32 and lo_o receives bits 31..0 of the unsigned 64-bit product of opa_i and opb_i.
- R3: Signed multiply (op_i = 2'b00): hi_o:lo_o holds the two's-complement 64-bit product. This includes operands equal to 32'h8000_0000.
- R4: Unsigned divide (op_i = 2'b11): lo_o receives opa_i / opb_i and hi_o receives opa_i mod opb_i.
- R5: Signed divide (op_i = 2'b10): the quotient rounds toward zero and the remainder takes the sign of the dividend. 32'h8000_0000 divided by 32'hFFFF_FFFF gives lo_o = 32'h8000_0000 and hi_o = 0.
- R6: A divide with opb_i = 0, signed or unsigned, sets lo_o to all ones and hi_o to the original opa_i. It completes with the normal timing.
- R7: A start pulse seen at a rising edge while idle is accepted. busy_o is then high for exactly 32 cycles. done_o is high for exactly one cycle, in the cycle where busy_o has fallen. hi_o and lo_o show the new result in that same cycle.
- R8: A start pulse that arrives while busy_o is high is ignored. The result is that of the accepted command, and the busy length does not change.
- R9: hi_o and lo_o change only in a done cycle. Operand or opcode changes without an accepted start have no effect on them.
- R10: Operands are captured at the accepting edge. Input changes during busy do not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle command strobe |
| op_i | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa_i | input | 32 | Multiplicand or dividend |
| opb_i | input | 32 | Multiplier or divisor |
| busy_o | output | 1 | High while the unit iterates |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | Move-from-HI read port (upper product or remainder) |
| lo_o | output | 32 | Move-from-LO read port (lower product or quotient) |

## Verification
A corrupted iteration counter appears at the ports as a busy window that is not 32 cycles long. This shows up at the very first completion after the fault. A wrong bit in the working register, the captured operand or a sign flag remains hidden until done, and then appears as a wrong HI or LO value in that done cycle, with nothing visible in between. For this reason every command is followed to its completion. The operands chosen include the most negative value, -1, zero divisors and negative dividends, so that sign-correction faults and divide-by-zero faults reach the read ports.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  // Bit 1 selects divide, bit 0 selects unsigned.
  typedef enum logic [1:0] {
    OP_MUL_S = 2'b00,
    OP_MUL_U = 2'b01,
    OP_DIV_S = 2'b10,
    OP_DIV_U = 2'b11
  } md_op_e;
endpackage

// File: rtl/muldiv_prep.sv
module muldiv_prep
  import muldiv_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  md_op_e            op,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  output logic [XLEN-1:0]   mag_a,
  output logic [XLEN-1:0]   mag_b,
  output logic              neg_main,
  output logic              neg_rem
);
  logic sgn_a, sgn_b;

  always_comb begin
    sgn_a    = (op[0] == 1'b0) && a[XLEN-1];
    sgn_b    = (op[0] == 1'b0) && b[XLEN-1];
    mag_a    = sgn_a ? (~a + 1'b1) : a;
    mag_b    = sgn_b ? (~b + 1'b1) : b;
    neg_main = sgn_a ^ sgn_b;
    neg_rem  = sgn_a;
  end
endmodule

// File: rtl/muldiv_step.sv
module muldiv_step #(
  parameter int XLEN = 32,
  localparam int DW = 2 * XLEN
) (
  input  logic            is_div,
  input  logic [DW-1:0]   work_i,
  input  logic [XLEN-1:0] mcand_i,
  output logic [DW-1:0]   work_o
);
  logic [XLEN:0]   mul_sum;
  logic [XLEN:0]   rem_sh;
  logic [XLEN-1:0] rem_dif;
  logic            borrow;

  always_comb begin
    // shift-and-add: add the operand to the upper half when the lsb is set, then shift right
    mul_sum = {1'b0, work_i[DW-1:XLEN]} + (work_i[0] ? {1'b0, mcand_i} : '0);
    // restoring step: shift the next dividend bit into the partial remainder, then try to subtract
    rem_sh  = {work_i[DW-1:XLEN], work_i[XLEN-1]};
    borrow  = rem_sh < {1'b0, mcand_i};
    rem_dif = rem_sh[XLEN-1:0] - mcand_i;
    if (!is_div)
      work_o = {mul_sum, work_i[XLEN-1:1]};
    else if (borrow)
      work_o = {rem_sh[XLEN-1:0], work_i[XLEN-2:0], 1'b0};
    else
      work_o = {rem_dif, work_i[XLEN-2:0], 1'b1};
  end
endmodule

// File: rtl/muldiv_fix.sv
module muldiv_fix #(
  parameter int XLEN = 32,
  localparam int DW = 2 * XLEN
) (
  input  logic            is_div,
  input  logic            neg_main,
  input  logic            neg_rem,
  input  logic            div_zero,
  input  logic [XLEN-1:0] dividend,
  input  logic [DW-1:0]   work,
  output logic [XLEN-1:0] hi,
  output logic [XLEN-1:0] lo
);
  logic [DW-1:0]   prod;
  logic [XLEN-1:0] quo, rem;

  always_comb begin
    prod = neg_main ? (~work + 1'b1) : work;
    quo  = neg_main ? (~work[XLEN-1:0] + 1'b1) : work[XLEN-1:0];
    rem  = neg_rem ? (~work[DW-1:XLEN] + 1'b1) : work[DW-1:XLEN];
    if (!is_div) begin
      hi = prod[DW-1:XLEN];
      lo = prod[XLEN-1:0];
    end else if (div_zero) begin
      hi = dividend;
      lo = '1;
    end else begin
      hi = rem;
      lo = quo;
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [1:0]      op_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] hi_o,
  output logic [XLEN-1:0] lo_o
);
  localparam int DW = 2 * XLEN;
  localparam int CW = $clog2(XLEN) + 1;
  localparam logic [CW-1:0] LAST = CW'(XLEN - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // state
  logic            busy_q, busy_d, done_q, done_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [DW-1:0]   work_q, work_d, work_step;
  logic [XLEN-1:0] mcand_q, mcand_d, dvd_q, dvd_d;
  logic            isdiv_q, isdiv_d, negm_q, negm_d, negr_q, negr_d, dz_q, dz_d;
  logic [XLEN-1:0] hi_q, hi_d, lo_q, lo_d, fix_hi, fix_lo;
  logic [XLEN-1:0] mag_a, mag_b;
  logic            p_negm, p_negr;
  logic            ld_en, step_en, fin_en;
  md_op_e          op_in;

  assign op_in = md_op_e'(op_i);

  muldiv_prep #(.XLEN(XLEN)) u_prep (
    .op(op_in), .a(opa_i), .b(opb_i),
    .mag_a(mag_a), .mag_b(mag_b), .neg_main(p_negm), .neg_rem(p_negr)
  );

  muldiv_step #(.XLEN(XLEN)) u_step (
    .is_div(isdiv_q), .work_i(work_q), .mcand_i(mcand_q), .work_o(work_step)
  );

  muldiv_fix #(.XLEN(XLEN)) u_fix (
    .is_div(isdiv_q), .neg_main(negm_q), .neg_rem(negr_q), .div_zero(dz_q),
    .dividend(dvd_q), .work(work_step), .hi(fix_hi), .lo(fix_lo)
  );

  // enables
  always_comb begin
    ld_en   = start_i && !busy_q;
    step_en = busy_q;
    fin_en  = busy_q && (cnt_q == LAST);
  end

  // next state
  always_comb begin
    busy_d  = busy_q;
    done_d  = fin_en;
    cnt_d   = cnt_q;
    work_d  = work_q;
    mcand_d = mcand_q;
    dvd_d   = dvd_q;
    isdiv_d = isdiv_q;
    negm_d  = negm_q;
    negr_d  = negr_q;
    dz_d    = dz_q;
    hi_d    = fix_hi;
    lo_d    = fix_lo;
    if (ld_en) begin
      busy_d  = 1'b1;
      cnt_d   = '0;
      isdiv_d = op_i[1];
      work_d  = op_i[1] ? {{XLEN{1'b0}}, mag_a} : {{XLEN{1'b0}}, mag_b};
      mcand_d = op_i[1] ? mag_b : mag_a;
      dvd_d   = opa_i;
      negm_d  = p_negm;
      negr_d  = p_negr;
      dz_d    = op_i[1] && (opb_i == '0);
    end else if (step_en) begin
      work_d = work_step;
      cnt_d  = cnt_q + 1'b1;
      if (fin_en) busy_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= done_d;
      if (ld_en || step_en) begin
        busy_q <= busy_d;
        cnt_q  <= cnt_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      work_q  <= '0;
      mcand_q <= '0;
      dvd_q   <= '0;
      isdiv_q <= 1'b0;
      negm_q  <= 1'b0;
      negr_q  <= 1'b0;
      dz_q    <= 1'b0;
    end else begin
      if (ld_en || step_en) work_q <= work_d;
      if (ld_en) begin
        mcand_q <= mcand_d;
        dvd_q   <= dvd_d;
        isdiv_q <= isdiv_d;
        negm_q  <= negm_d;
        negr_q  <= negr_d;
        dz_q    <= dz_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (fin_en) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
endmodule

// File: rtl/muldiv_chk.sv
module muldiv_chk
  import muldiv_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [1:0]      op_i,
  input logic [XLEN-1:0] opa_i,
  input logic [XLEN-1:0] opb_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [XLEN-1:0] hi_o,
  input logic [XLEN-1:0] lo_o
);
  localparam int BW = $clog2(XLEN) + 2;

  logic [BW-1:0]   blen_q;
  logic [1:0]      cap_op;
  logic [XLEN-1:0] cap_a, cap_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blen_q <= '0;
      cap_op <= 2'b00;
      cap_a  <= '0;
      cap_b  <= '0;
    end else begin
      blen_q <= busy_o ? blen_q + 1'b1 : '0;
      if (start_i && !busy_o) begin
        cap_op <= op_i;
        cap_a  <= opa_i;
        cap_b  <= opb_i;
      end
    end
  end

  // R7, R8: the busy window is exactly XLEN cycles, even when starts arrive during it
  a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (blen_q == BW'(XLEN)));

  // R7: done marks the fall of busy and lasts one cycle
  a_r7_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $fell(busy_o));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: HI and LO move only in a done cycle
  a_r9_hilo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(hi_o) && $stable(lo_o)));

  // R6: a zero divisor yields all ones in LO and the dividend in HI
  a_r6_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (cap_op == OP_DIV_S || cap_op == OP_DIV_U) && cap_b == '0)
      |-> (lo_o == '1 && hi_o == cap_a));
endmodule

bind muldiv_unit muldiv_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
  .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
  .hi_o(hi_o), .lo_o(lo_o)
);

// File: tb/tb_muldiv_unit.sv
`timescale 1ns/1ps
module tb_muldiv_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic        busy_o, done_o;
  logic [31:0] hi_o, lo_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  muldiv_unit dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
    .hi_o(hi_o), .lo_o(lo_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    longint unsigned ua, ub;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = {32'b0, a};
    ub = {32'b0, b};
    case (op)
      2'b00: model = sa * sb;
      2'b01: model = ua * ub;
      default: begin
        if (b == 0) model = {a, 32'hFFFF_FFFF};
        else if (op == 2'b11) model = {32'(ua % ub), 32'(ua / ub)};
        else begin
          q = sa / sb;
          r = sa % sb;
          model = {r[31:0], q[31:0]};
        end
      end
    endcase
  endfunction

  // one command; intrude_at > 0 injects a foreign start in that busy cycle
  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                        input string req, input int intrude_at);
    logic [63:0] exp;
    int n;
    exp = model(op, a, b);
    @(negedge clk);
    op_i = op; opa_i = a; opb_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    opa_i = $urandom; opb_i = $urandom; op_i = 2'($urandom);  // R10: late changes
    n = 0;
    while (busy_o && n < 100) begin
      n++;
      if (n == intrude_at) begin
        start_i = 1'b1; op_i = 2'b01; opa_i = '1; opb_i = '1;
      end
      @(negedge clk);
      start_i = 1'b0;
    end
    chk(n == 32, "R7 busy length", 64'(n), 64'd32);
    chk(done_o == 1'b1, "R7 done with busy fall", 64'(done_o), 64'd1);
    chk({hi_o, lo_o} == exp, req, {hi_o, lo_o}, exp);
    @(negedge clk);
    chk(done_o == 1'b0, "R7 done single cycle", 64'(done_o), 64'd0);
    chk({hi_o, lo_o} == exp, "R9 result held", {hi_o, lo_o}, exp);
  endtask

  task automatic t_reset();
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1 flags in reset", {62'b0, busy_o, done_o}, 64'd0);
    chk({hi_o, lo_o} == 64'd0, "R1 HI/LO in reset", {hi_o, lo_o}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1 flags after reset", {62'b0, busy_o, done_o}, 64'd0);
    chk({hi_o, lo_o} == 64'd0, "R1 HI/LO after reset", {hi_o, lo_o}, 64'd0);
  endtask

  task automatic t_umul();
    run_op(2'b01, 32'd7, 32'd9, "R2 small", 0);
    run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 max", 0);
    run_op(2'b01, 32'h8000_0000, 32'd2, "R2 carry to HI", 0);
    run_op(2'b01, 32'h1234_5678, 32'd0, "R2 zero", 0);
  endtask

  task automatic t_smul();
    run_op(2'b00, 32'hFFFF_FFFF, 32'd5, "R3 neg*pos", 0);
    run_op(2'b00, 32'hFFFF_FFF9, 32'hFFFF_FFFD, "R3 neg*neg", 0);
    run_op(2'b00, 32'h8000_0000, 32'h8000_0000, "R3 min*min", 0);
    run_op(2'b00, 32'h8000_0000, 32'hFFFF_FFFF, "R3 min*-1", 0);
    run_op(2'b00, 32'h7FFF_FFFF, 32'h8000_0000, "R3 max*min", 0);
  endtask

  task automatic t_udiv();
    run_op(2'b11, 32'd100, 32'd7, "R4 small", 0);
    run_op(2'b11, 32'hFFFF_FFFF, 32'd1, "R4 by one", 0);
    run_op(2'b11, 32'd3, 32'hFFFF_FFFF, "R4 divisor larger", 0);
    run_op(2'b11, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R4 near max", 0);
  endtask

  task automatic t_sdiv();
    run_op(2'b10, 32'hFFFF_FF9C, 32'd7, "R5 neg/pos", 0);
    run_op(2'b10, 32'd100, 32'hFFFF_FFF9, "R5 pos/neg", 0);
    run_op(2'b10, 32'hFFFF_FF9C, 32'hFFFF_FFF9, "R5 neg/neg", 0);
    run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, "R5 min/-1", 0);
    run_op(2'b10, 32'h8000_0000, 32'd1, "R5 min/1", 0);
  endtask

  task automatic t_divzero();
    run_op(2'b11, 32'hDEAD_BEEF, 32'd0, "R6 unsigned by zero", 0);
    run_op(2'b10, 32'hFFFF_FF00, 32'd0, "R6 signed neg by zero", 0);
    run_op(2'b10, 32'h0000_0042, 32'd0, "R6 signed pos by zero", 0);
  endtask

  task automatic t_busy_start();
    run_op(2'b11, 32'd1000, 32'd33, "R8 start mid-busy ignored", 5);
    run_op(2'b00, 32'd3, 32'd4, "R8 start on first busy cycle ignored", 1);
  endtask

  task automatic t_idle_hold();
    logic [63:0] held;
    held = {hi_o, lo_o};
    @(negedge clk);
    op_i = 2'b01; opa_i = 32'hAAAA_5555; opb_i = 32'h1357_9BDF;
    repeat (6) @(negedge clk);
    chk({hi_o, lo_o} == held, "R9 idle inputs ignored", {hi_o, lo_o}, held);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R9 no activity without start",
        {62'b0, busy_o, done_o}, 64'd0);
  endtask

  task automatic t_random();
    for (int k = 0; k < 48; k++) begin
      logic [31:0] a, b;
      logic [1:0] op;
      op = 2'(k % 4);
      a = $urandom; b = $urandom;
      if (k % 7 == 3) a = 32'h8000_0000;
      if (k % 11 == 5) b = 32'hFFFF_FFFF;
      if (k % 5 == 1) b = b >> 20;
      case (op)
        2'b00: run_op(op, a, b, "R3 random", 0);
        2'b01: run_op(op, a, b, "R2 random", 0);
        2'b10: run_op(op, a, b, "R5 random", 0);
        default: run_op(op, a, b, "R4 random", 0);
      endcase
    end
  endtask

  initial begin
    #(750000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_umul();
    t_smul();
    t_udiv();
    t_sdiv();
    t_divzero();
    t_busy_start();
    t_idle_hold();
    t_random();
    t_idle_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule